// File: doc/BRIEF.md
# Predicated Vector Reverse-Within-Elements Unit

This block executes one predicated vector permute instruction per cycle on a 128-bit vector. The instruction picks an element size (byte, halfword, word or doubleword) and a reversal granule (bytes, halfwords, words or single bits). Inside every element, the order of the granules is reversed. The order of the elements across the vector does not change.

Each element is governed by the predicate bit of its lowest byte lane. Active elements receive the transformed source. Inactive elements keep the old destination value. An instruction word that does not carry the expected fixed bits is rejected. So is a granule wider than or equal to the element, except for bit reversal. A rejected instruction raises an illegal flag and its write-enable stays low.

The result, write-enable, illegal flag and decoded register selectors are registered. They appear one cycle after the issue strobe.

Top module: `vrev_unit`

## Requirements
- R1: An instruction matches only when bits [31:24] = 8'b00000101, bits [21:18] = 4'b1001 and bits [15:13] = 3'b100. A valid non-matching word gives out_illegal=1 and out_wr_en=0.
- R2: Operation code bits [17:16]=2'b00 reverses the byte order inside each element. The element size is taken from bits [23:22], where 1=16, 2=32 and 3=64 bits.
- R3: Operation code 2'b01 reverses the halfword order inside each 32-bit or 64-bit element.
- R4: Operation code 2'b10 swaps the two 32-bit words of each 64-bit element.
- R5: Operation code 2'b11 reverses the bit order inside each element, at all four element sizes including bytes.
- R6: A reversal granule whose width is at least the element width is illegal: out_illegal=1, out_wr_en=0, and the result equals the old destination value. Bit reversal is exempt from this rule.
- R7: An element is active exactly when the in_pred bit of its lowest byte lane (bit index = element index × element bytes) is 1. The other predicate bits have no effect.
- R8: An inactive element of a legal instruction keeps the old destination bits (merging).
- R9: The outputs are registered with one cycle of latency. out_valid follows in_valid by one cycle. out_wr_en and out_illegal are never high without out_valid, and never high together.
- R10: The selector fields bits [4:0] (destination), [9:5] (source) and [12:10] (predicate) appear on out_dst_sel, out_src_sel and out_pred_sel one cycle after issue.
- R11: A synchronous active-high reset clears out_valid, out_wr_en, out_illegal, the selectors and out_result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for one instruction |
| in_insn | input | 32 | Instruction word |
| in_src | input | 128 | Source vector |
| in_old_dst | input | 128 | Current destination vector, used for merging |
| in_pred | input | 16 | Governing predicate, one bit per byte lane |
| out_valid | output | 1 | A result is presented this cycle |
| out_wr_en | output | 1 | Destination should be written (legal instruction) |
| out_illegal | output | 1 | Instruction did not match or size/operation pair not allowed |
| out_dst_sel | output | 5 | Destination register selector |
| out_src_sel | output | 5 | Source register selector |
| out_pred_sel | output | 3 | Predicate register selector |
| out_result | output | 128 | Merged result vector |

## Verification
On every cycle, the assertions check:
- the one-cycle valid timing;
- that the write-enable and illegal flags are exclusive and qualified by valid;
- that selector fields pass through;
- that a wrong fixed opcode byte is rejected;
- that an all-zero predicate returns the old destination.

Only the bench scenarios can show the permutation content of each legal size/operation pair, against a bench model written from granule index arithmetic. The same holds for the exact active-lane rule and for the set of rejected pairs.

// File: rtl/vrev_pkg.sv
package vrev_pkg;

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  typedef enum logic [1:0] {
    ROP_BYTES  = 2'd0,
    ROP_HALVES = 2'd1,
    ROP_WORDS  = 2'd2,
    ROP_BITS   = 2'd3
  } rop_e;

  localparam logic [7:0] FIX_HI  = 8'b0000_0101;
  localparam logic [3:0] FIX_MID = 4'b1001;
  localparam logic [2:0] FIX_LO  = 3'b100;

  typedef struct packed {
    logic       match;
    logic       legal;
    esz_e       esz;
    rop_e       op;
    logic [2:0] pg;
    logic [4:0] zn;
    logic [4:0] zd;
  } dec_t;

  localparam logic [63:0] HALF_PAIR_MASK = 64'h0000_ffff_0000_ffff;

endpackage

// File: rtl/vrev_decode.sv
module vrev_decode
  import vrev_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  logic fix_ok;

  always_comb begin
    fix_ok    = (insn[31:24] == FIX_HI) && (insn[21:18] == FIX_MID) &&
                (insn[15:13] == FIX_LO);
    dec.match = fix_ok;
    dec.esz   = esz_e'(insn[23:22]);
    dec.op    = rop_e'(insn[17:16]);
    dec.pg    = insn[12:10];
    dec.zn    = insn[9:5];
    dec.zd    = insn[4:0];
    // granule must be narrower than the element, bit reversal always fits
    dec.legal = fix_ok && ((insn[17:16] == 2'd3) || (insn[23:22] > insn[17:16]));
  end
endmodule

// File: rtl/vrev_dword_xform.sv
module vrev_dword_xform
  import vrev_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] din,
  input  esz_e          esz,
  input  rop_e          op,
  output logic [DW-1:0] dout
);
  localparam int NBYTES = DW / 8;

  logic [DW-1:0] byt_h, byt_w, byt_d;
  logic [DW-1:0] hlf_w, hlf_d, wrd_d, rot32;
  logic [DW-1:0] bit_b, bit_h, bit_w, bit_d;

  always_comb begin
    for (int j = 0; j < NBYTES; j++) begin
      byt_h[8*j +: 8] = din[8*(j ^ 1) +: 8];
      byt_w[8*j +: 8] = din[8*(j ^ 3) +: 8];
      byt_d[8*j +: 8] = din[8*(j ^ 7) +: 8];
    end
    for (int i = 0; i < DW; i++) begin
      bit_b[i] = din[i ^ 7];
      bit_h[i] = din[i ^ 15];
      bit_w[i] = din[i ^ 31];
      bit_d[i] = din[i ^ 63];
    end
    for (int w = 0; w < DW / 32; w++) begin
      hlf_w[32*w +: 32] = {din[32*w +: 16], din[32*w+16 +: 16]};
    end
    rot32 = {din[31:0], din[63:32]};
    wrd_d = rot32;
    hlf_d = ((rot32 & HALF_PAIR_MASK) << 16) | ((rot32 >> 16) & HALF_PAIR_MASK);

    dout = din;
    unique case (op)
      ROP_BYTES: begin
        case (esz)
          ESZ_H:   dout = byt_h;
          ESZ_W:   dout = byt_w;
          ESZ_D:   dout = byt_d;
          default: dout = din;
        endcase
      end
      ROP_HALVES: begin
        case (esz)
          ESZ_W:   dout = hlf_w;
          ESZ_D:   dout = hlf_d;
          default: dout = din;
        endcase
      end
      ROP_WORDS: dout = (esz == ESZ_D) ? wrd_d : din;
      ROP_BITS: begin
        case (esz)
          ESZ_B:   dout = bit_b;
          ESZ_H:   dout = bit_h;
          ESZ_W:   dout = bit_w;
          default: dout = bit_d;
        endcase
      end
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/vrev_merge.sv
module vrev_merge
  import vrev_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic [8*LANES-1:0] xf,
  input  logic [8*LANES-1:0] old,
  input  logic [LANES-1:0]   pred,
  input  esz_e               esz,
  output logic [8*LANES-1:0] merged
);
  logic [LANES-1:0] act;

  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      int base;
      base   = b & ~((1 << esz) - 1);
      act[b] = pred[base];
      merged[8*b +: 8] = act[b] ? xf[8*b +: 8] : old[8*b +: 8];
    end
  end
endmodule

// File: rtl/vrev_unit.sv
module vrev_unit
  import vrev_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int IW   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [IW-1:0]     in_insn,
  input  logic [VLEN-1:0]   in_src,
  input  logic [VLEN-1:0]   in_old_dst,
  input  logic [VLEN/8-1:0] in_pred,
  output logic              out_valid,
  output logic              out_wr_en,
  output logic              out_illegal,
  output logic [4:0]        out_dst_sel,
  output logic [4:0]        out_src_sel,
  output logic [2:0]        out_pred_sel,
  output logic [VLEN-1:0]   out_result
);
  localparam int NDW   = VLEN / 64;
  localparam int LANES = VLEN / 8;

  dec_t            dec;
  logic [VLEN-1:0] xf_vec;
  logic [VLEN-1:0] merged;

  vrev_decode u_dec (
    .insn (in_insn[31:0]),
    .dec  (dec)
  );

  for (genvar d = 0; d < NDW; d++) begin : g_dw
    vrev_dword_xform #(.DW(64)) u_xf (
      .din  (in_src[64*d +: 64]),
      .esz  (dec.esz),
      .op   (dec.op),
      .dout (xf_vec[64*d +: 64])
    );
  end

  vrev_merge #(.LANES(LANES)) u_merge (
    .xf     (xf_vec),
    .old    (in_old_dst),
    .pred   (in_pred),
    .esz    (dec.esz),
    .merged (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_wr_en    <= 1'b0;
      out_illegal  <= 1'b0;
      out_dst_sel  <= '0;
      out_src_sel  <= '0;
      out_pred_sel <= '0;
      out_result   <= '0;
    end else begin
      out_valid   <= in_valid;
      out_wr_en   <= in_valid && dec.legal;
      out_illegal <= in_valid && !dec.legal;
      if (in_valid) begin
        out_dst_sel  <= dec.zd;
        out_src_sel  <= dec.zn;
        out_pred_sel <= dec.pg;
        out_result   <= dec.legal ? merged : in_old_dst;
      end
    end
  end
endmodule

// File: rtl/vrev_unit_chk.sv
module vrev_unit_chk #(
  parameter int VLEN = 128,
  parameter int IW   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [IW-1:0]     in_insn,
  input logic [VLEN-1:0]   in_src,
  input logic [VLEN-1:0]   in_old_dst,
  input logic [VLEN/8-1:0] in_pred,
  input logic              out_valid,
  input logic              out_wr_en,
  input logic              out_illegal,
  input logic [4:0]        out_dst_sel,
  input logic [4:0]        out_src_sel,
  input logic [2:0]        out_pred_sel,
  input logic [VLEN-1:0]   out_result
);
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_follows_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_flags_need_valid_r9: assert property (@(posedge clk) disable iff (rst)
    (out_wr_en || out_illegal) |-> out_valid);
  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(out_wr_en && out_illegal));
  p_nonmatch_illegal_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_insn[31:24] != 8'b0000_0101) |=> (out_illegal && !out_wr_en));
  p_selectors_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_dst_sel == $past(in_insn[4:0]) &&
                  out_src_sel == $past(in_insn[9:5]) &&
                  out_pred_sel == $past(in_insn[12:10])));
  p_zero_pred_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pred == '0) |=> out_result == $past(in_old_dst));
endmodule

bind vrev_unit vrev_unit_chk #(.VLEN(VLEN), .IW(IW)) chk_i (.*);

// File: tb/vrev_unit_tb_top.sv
module vrev_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [31:0]  in_insn;
  logic [127:0] in_src, in_old_dst;
  logic [15:0]  in_pred;
  logic         out_valid, out_wr_en, out_illegal;
  logic [4:0]   out_dst_sel, out_src_sel;
  logic [2:0]   out_pred_sel;
  logic [127:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vrev_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .in_src(in_src), .in_old_dst(in_old_dst), .in_pred(in_pred),
    .out_valid(out_valid), .out_wr_en(out_wr_en), .out_illegal(out_illegal),
    .out_dst_sel(out_dst_sel), .out_src_sel(out_src_sel),
    .out_pred_sel(out_pred_sel), .out_result(out_result)
  );

  function automatic logic [31:0] mk_insn(int esz, int op, int pg, int zn, int zd);
    return {8'b0000_0101, 2'(esz), 4'b1001, 2'(op), 3'b100, 3'(pg), 5'(zn), 5'(zd)};
  endfunction

  function automatic bit is_legal(int esz, int op);
    return (op == 3) || (esz > op);
  endfunction

  function automatic logic [127:0] model(int esz, int op, logic [127:0] src,
                                         logic [127:0] old, logic [15:0] pred);
    logic [127:0] r;
    int ebits, nel, gb, ng, s;
    ebits = 8 << esz;
    nel   = 128 / ebits;
    r     = old;
    for (int e = 0; e < nel; e++) begin
      if (pred[e * (ebits / 8)]) begin
        for (int k = 0; k < ebits; k++) begin
          if (op == 3) s = ebits - 1 - k;
          else begin
            gb = 8 << op;
            ng = ebits / gb;
            s  = (ng - 1 - k / gb) * gb + (k % gb);
          end
          r[e * ebits + k] = src[e * ebits + s];
        end
      end
    end
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] insn, logic [127:0] src, logic [127:0] old,
                       logic [15:0] pred);
    in_insn = insn; in_src = src; in_old_dst = old; in_pred = pred;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(string req, int esz, int op, logic [127:0] src,
                         logic [127:0] old, logic [15:0] pred);
    bit lg;
    lg = is_legal(esz, op);
    issue(mk_insn(esz, op, 5, 17, 9), src, old, pred);
    chk({req, " valid"}, 128'(out_valid), 128'd1);
    chk({req, " wr_en"}, 128'(out_wr_en), 128'(lg));
    chk({req, " illegal"}, 128'(out_illegal), 128'(!lg));
    chk({req, " result"}, out_result, lg ? model(esz, op, src, old, pred) : old);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] ramp, a, b;
    logic [31:0] w;
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; in_insn = '0; in_src = '0; in_old_dst = '0; in_pred = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 valid", 128'(out_valid), 128'd0);
    chk("R11 flags", 128'({out_wr_en, out_illegal}), 128'd0);
    chk("R11 sel", 128'({out_dst_sel, out_src_sel, out_pred_sel}), 128'd0);
    chk("R11 result", out_result, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle", 128'(out_valid), 128'd0);

    ramp = 128'h0f0e0d0c0b0a09080706050403020100;
    // R2 hand-computed byte reversal in doublewords
    issue(mk_insn(3, 0, 0, 1, 2), ramp, '0, 16'hffff);
    chk("R2 bytes-in-dword", out_result, 128'h08090a0b0c0d0e0f_0001020304050607);
    // R4 hand-computed word swap
    issue(mk_insn(3, 2, 0, 1, 2), ramp, '0, 16'hffff);
    chk("R4 words-in-dword", out_result, 128'h0b0a09080f0e0d0c_0302010007060504);
    // R3 halfwords in dword
    issue(mk_insn(3, 1, 0, 1, 2), ramp, '0, 16'hffff);
    chk("R3 halves-in-dword", out_result, 128'h09080b0a0d0c0f0e_0100030205040706);
    // R5 byte bit reversal
    issue(mk_insn(0, 3, 0, 1, 2), {16{8'h01}}, '0, 16'hffff);
    chk("R5 bits-in-byte", out_result, {16{8'h80}});

    // R10 selectors
    issue(mk_insn(2, 3, 6, 21, 30), ramp, '0, 16'hffff);
    chk("R10 sel", 128'({out_dst_sel, out_src_sel, out_pred_sel}), 128'({5'd30, 5'd21, 3'd6}));

    // every size/op pair, full and random predicates (R2 R3 R4 R5 R6)
    for (int es = 0; es < 4; es++)
      for (int op = 0; op < 4; op++) begin
        a = {$urandom(), $urandom(), $urandom(), $urandom()};
        b = {$urandom(), $urandom(), $urandom(), $urandom()};
        run_one(op == 0 ? "R2" : op == 1 ? "R3" : op == 2 ? "R4" : "R5", es, op, a, b, 16'hffff);
        if (!is_legal(es, op)) run_one("R6", es, op, a, b, 16'(($urandom())));
      end

    // R7 only non-lowest bits of each element set: nothing active
    a = {$urandom(), $urandom(), $urandom(), $urandom()};
    b = {$urandom(), $urandom(), $urandom(), $urandom()};
    issue(mk_insn(3, 3, 0, 0, 0), a, b, 16'hfefe);
    chk("R7 ignored pred bits dword", out_result, b);
    issue(mk_insn(2, 0, 0, 0, 0), a, b, 16'heeee);
    chk("R7 ignored pred bits word", out_result, b);
    // R8 zero predicate merges old value
    issue(mk_insn(1, 3, 0, 0, 0), a, b, 16'h0000);
    chk("R8 merge all", out_result, b);
    run_one("R8 alt lanes", 1, 0, a, b, 16'h5555);

    // R1 non-matching encodings
    w = mk_insn(3, 3, 0, 0, 0);
    issue(w ^ 32'h0100_0000, a, b, 16'hffff);
    chk("R1 bad hi illegal", 128'({out_illegal, out_wr_en}), 128'b10);
    issue(w ^ 32'h0004_0000, a, b, 16'hffff);
    chk("R1 bad mid illegal", 128'({out_illegal, out_wr_en}), 128'b10);
    issue(w ^ 32'h0000_2000, a, b, 16'hffff);
    chk("R1 bad lo illegal", 128'({out_illegal, out_wr_en}), 128'b10);
    chk("R1 bad lo result", out_result, b);

    // R9 back-to-back then idle
    in_insn = mk_insn(3, 2, 0, 0, 0); in_src = a; in_old_dst = b; in_pred = 16'hffff;
    in_valid = 1'b1;
    @(negedge clk);
    in_insn = mk_insn(2, 1, 0, 0, 0);
    @(negedge clk);
    chk("R9 back-to-back", out_result, model(2, 1, a, b, 16'hffff));
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle after", 128'({out_valid, out_wr_en, out_illegal}), 128'd0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int es, op;
      es = int'($urandom() % 4);
      op = int'($urandom() % 4);
      a = {$urandom(), $urandom(), $urandom(), $urandom()};
      b = {$urandom(), $urandom(), $urandom(), $urandom()};
      run_one("R7 R8 random", es, op, a, b, 16'($urandom()));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule